// File: doc/BRIEF.md
# Tagged Two-Way Message Mailbox

This block passes 32-bit messages between a host processor and a coprocessor. Each message has a 4-bit channel tag in its low bits and a 28-bit payload above it. Each direction has its own first-in first-out queue, and a queue keeps arrival order whatever the channel. The host sees a small register window with three live offsets. Reading the inbox register removes the oldest coprocessor-to-host message. The status word reports the inbox-empty flag and the outbox-full flag in its two top bits. Writing the outbox register queues a host-to-coprocessor message.

The coprocessor side is a plain handshake port. It pushes messages toward the host and pops messages that the host sent. The host bus uses single-cycle read and write strobes. Read data appears from a register one cycle after the read strobe. The empty and full flags take up a change on the cycle after the push or pop that causes it. A host write into a full outbox is lost and sets a sticky overflow flag, which is visible only on a debug output.

Top module: `tagmbox_top`

## Requirements
- R1: After reset both queues are empty. The status word reads 0x4000_0000 (bit 30 set for inbox empty, bit 31 clear), and the overflow debug flag is low.
- R2: A host read strobe at offset 0x00 returns the oldest pending coprocessor-to-host word on `hst_rdata` in the next cycle, and removes that word from the inbox.
- R3: A message word has its channel tag in bits [3:0] and its payload in bits [31:4]. The block passes all 32 bits through unchanged in both directions.
- R4: Status offset 0x18 returns bit 30 set exactly when the inbox holds no message, and bit 31 set exactly when the outbox holds 8 messages. Bits [29:0] read as zero.
- R5: A host write strobe at offset 0x20 appends the write data to the outbox. The coprocessor then receives the outbox words in write order on `cop_rx_data`, while `cop_rx_valid` is high, and `cop_rx_pop` consumes each one.
- R6: Each queue holds 8 messages and preserves order regardless of channel tag. The coprocessor's inbox push is accepted only while `cop_tx_ready` is high.
- R7: A host write to a full outbox is dropped, leaving the queue contents unchanged. It sets `dbg_overflow`, which stays high until reset.
- R8: A host read of offset 0x00 while the inbox is empty returns zero and does not change the inbox.
- R9: Reads of any offset other than 0x00, 0x18 and 0x20 return zero. Writes to any offset other than 0x20, including the status offset, change nothing.
- R10: The status flags and the coprocessor-side ready and valid signals change in the cycle after the push or pop that changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 6 | Byte offset within the mailbox window |
| hst_rd | input | 1 | Single-cycle read strobe |
| hst_wr | input | 1 | Single-cycle write strobe |
| hst_wdata | input | 32 | Write data |
| hst_rdata | output | 32 | Registered read data |
| cop_tx_push | input | 1 | Coprocessor pushes a word toward the host |
| cop_tx_data | input | 32 | Word pushed by the coprocessor |
| cop_tx_ready | output | 1 | Inbox can accept a push |
| cop_rx_valid | output | 1 | Outbox holds a word for the coprocessor |
| cop_rx_data | output | 32 | Oldest outbox word |
| cop_rx_pop | input | 1 | Coprocessor consumes the oldest outbox word |
| dbg_overflow | output | 1 | Sticky flag for a dropped host write |

## Verification
On every cycle, the assertions check the following:
- The occupancy counters stay within bounds.
- The registered flags track occupancy one cycle late.
- The status word has zero bits in [29:0].
- An empty read returns zero.
- The overflow flag never falls.
- A write into a full outbox leaves the count unchanged.

Only the bench's scenarios can show the rest:
- message order through each queue, including wrap-around of the pointers;
- that tags and payloads survive intact;
- that an empty read leaves later data intact;
- that stray writes, including writes to the status offset, have no visible effect.

The bench sweeps every window offset and fills each queue past its depth.

// File: rtl/tagmbox_pkg.sv
package tagmbox_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ADDR_W  = 6;
  localparam logic [ADDR_W-1:0] OFS_INBOX  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_OUTBOX = 6'h20;
  localparam int unsigned BIT_EMPTY = 30;
  localparam int unsigned BIT_FULL  = 31;

  typedef enum logic [1:0] {SEL_NONE, SEL_INBOX, SEL_STATUS, SEL_OUTBOX} reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_INBOX:  return SEL_INBOX;
      OFS_STATUS: return SEL_STATUS;
      OFS_OUTBOX: return SEL_OUTBOX;
      default:    return SEL_NONE;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic empty, input logic full);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BIT_EMPTY] = empty;
    w[BIT_FULL]  = full;
    return w;
  endfunction
endpackage

// File: rtl/tagmbox_fifo.sv
module tagmbox_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic             push_ok,
  output logic             pop_ok
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0; empty <= 1'b1; full <= 1'b0;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
      case ({push_ok, pop_ok})
        2'b10: begin count <= count + 1'b1; empty <= 1'b0; full <= (count + 1'b1 == DEPTH_C); end
        2'b01: begin count <= count - 1'b1; full <= 1'b0; empty <= (count == CW'(1)); end
        default: ;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count <= DEPTH_C); // R6
  AST_EMPTY_TRACK: assert property (@(posedge clk) disable iff (!rst_n) empty == (count == '0)); // R10
  AST_FULL_TRACK:  assert property (@(posedge clk) disable iff (!rst_n) full == (count == DEPTH_C)); // R10
  AST_FULL_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (full && push && !pop) |=> (count == DEPTH_C)); // R7
endmodule

// File: rtl/tagmbox_regs.sv
module tagmbox_regs
  import tagmbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [WORD_W-1:0] inbox_head,
  input  logic              inbox_empty,
  input  logic              outbox_full,
  output logic              inbox_pop,
  output logic              outbox_push,
  output logic              wr_drop,
  output logic [WORD_W-1:0] rdata
);
  reg_sel_e sel;
  logic [WORD_W-1:0] rd_mux;

  assign sel         = decode_ofs(addr);
  assign inbox_pop   = rd && (sel == SEL_INBOX);
  assign outbox_push = wr && (sel == SEL_OUTBOX);
  assign wr_drop     = outbox_push && outbox_full;

  always_comb begin
    case (sel)
      SEL_INBOX:  rd_mux = inbox_empty ? '0 : inbox_head;
      SEL_STATUS: rd_mux = status_word(inbox_empty, outbox_full);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (inbox_pop && inbox_empty) |=> (rdata == '0)); // R8
  AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_STATUS) |=> (rdata[29:0] == '0)); // R4
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_NONE) |=> (rdata == '0)); // R9
endmodule

// File: rtl/tagmbox_top.sv
module tagmbox_top
  import tagmbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic              hst_rd,
  input  logic              hst_wr,
  input  logic [WORD_W-1:0] hst_wdata,
  output logic [WORD_W-1:0] hst_rdata,
  input  logic              cop_tx_push,
  input  logic [WORD_W-1:0] cop_tx_data,
  output logic              cop_tx_ready,
  output logic              cop_rx_valid,
  output logic [WORD_W-1:0] cop_rx_data,
  input  logic              cop_rx_pop,
  output logic              dbg_overflow
);
  logic [WORD_W-1:0] inbox_head;
  logic inbox_empty, inbox_full, inbox_push_ok, inbox_pop_ok;
  logic outbox_empty, outbox_full, outbox_push_ok, outbox_pop_ok;
  logic inbox_pop, outbox_push, wr_drop;

  tagmbox_regs u_regs (
    .clk, .rst_n, .addr(hst_addr), .rd(hst_rd), .wr(hst_wr),
    .inbox_head, .inbox_empty, .outbox_full,
    .inbox_pop, .outbox_push, .wr_drop, .rdata(hst_rdata)
  );

  tagmbox_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_inbox (
    .clk, .rst_n, .push(cop_tx_push), .push_data(cop_tx_data), .pop(inbox_pop),
    .head(inbox_head), .empty(inbox_empty), .full(inbox_full),
    .push_ok(inbox_push_ok), .pop_ok(inbox_pop_ok)
  );

  tagmbox_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_outbox (
    .clk, .rst_n, .push(outbox_push), .push_data(hst_wdata), .pop(cop_rx_pop),
    .head(cop_rx_data), .empty(outbox_empty), .full(outbox_full),
    .push_ok(outbox_push_ok), .pop_ok(outbox_pop_ok)
  );

  assign cop_tx_ready = !inbox_full;
  assign cop_rx_valid = !outbox_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) dbg_overflow <= 1'b0;
    else if (wr_drop) dbg_overflow <= 1'b1;
  end

  AST_NO_OVERFLOW_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dbg_overflow) |-> dbg_overflow); // R7
  AST_DROP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> dbg_overflow); // R7
  AST_DROP_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> !outbox_push_ok); // R7
  AST_READY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cop_tx_ready) |-> $past(inbox_pop_ok)); // R10
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cop_rx_valid) |-> $past(outbox_push_ok)); // R10
  AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    inbox_push_ok |-> cop_tx_ready); // R6
endmodule

// File: tb/sim_tagmbox_top.sv
module sim_tagmbox_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] hst_addr = '0;
  logic hst_rd = 1'b0, hst_wr = 1'b0;
  logic [31:0] hst_wdata = '0, cop_tx_data = '0;
  logic cop_tx_push = 1'b0, cop_rx_pop = 1'b0;
  logic [31:0] hst_rdata, cop_rx_data;
  logic cop_tx_ready, cop_rx_valid, dbg_overflow;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  tagmbox_top u0 (.*);

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] msg(input int ch, input int pay);
    return {28'(pay), 4'(ch)};
  endfunction

  function automatic logic [31:0] stat(input logic e, input logic f);
    return {f, e, 30'd0};
  endfunction

  task automatic hread(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); hst_addr = a; hst_rd = 1'b1;
    @(negedge clk); hst_rd = 1'b0; d = hst_rdata;
  endtask

  task automatic hwrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk); hst_wr = 1'b0;
  endtask

  task automatic cpush(input logic [31:0] d);
    @(negedge clk); cop_tx_data = d; cop_tx_push = 1'b1;
    @(negedge clk); cop_tx_push = 1'b0;
  endtask

  task automatic cpop(output logic [31:0] d);
    @(negedge clk); d = cop_rx_data; cop_rx_pop = 1'b1;
    @(negedge clk); cop_rx_pop = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hread(6'h18, d); chk("R1 status after reset", d, stat(1, 0));
    chk("R1 overflow after reset", {31'd0, dbg_overflow}, 32'd0);
    chk("R1 rx_valid after reset", {31'd0, cop_rx_valid}, 32'd0);
    chk("R1 tx_ready after reset", {31'd0, cop_tx_ready}, 32'd1);

    hread(6'h00, d); chk("R8 empty read", d, 32'd0);
    hread(6'h18, d); chk("R8 still empty", d, stat(1, 0));

    for (int round = 0; round < 3; round++) begin
      for (int i = 0; i < 5; i++) cpush(msg((i * 7 + round) % 16, 32'h0ABC_DE0 + i * 33 + round));
      hread(6'h18, d); chk("R4 inbox nonempty", d, stat(0, 0));
      for (int i = 0; i < 5; i++) begin
        hread(6'h00, d);
        chk("R2 R3 inbox order", d, msg((i * 7 + round) % 16, 32'h0ABC_DE0 + i * 33 + round));
      end
      hread(6'h18, d); chk("R4 inbox empty again", d, stat(1, 0));
    end

    for (int i = 0; i < 9; i++) begin
      @(negedge clk); cop_tx_data = msg(i, 32'h0F00 + i); cop_tx_push = 1'b1;
      @(negedge clk); cop_tx_push = 1'b0;
      chk("R10 R6 tx_ready after push", {31'd0, cop_tx_ready}, {31'd0, (i < 7)});
    end
    for (int i = 0; i < 8; i++) begin
      hread(6'h00, d); chk("R6 inbox keeps 8, drops 9th", d, msg(i, 32'h0F00 + i));
    end
    hread(6'h00, d); chk("R8 drained read", d, 32'd0);

    hwrite(6'h20, msg(1, 32'h1234567));
    chk("R10 rx_valid after write", {31'd0, cop_rx_valid}, 32'd1);
    cpop(d); chk("R5 outbox word", d, msg(1, 32'h1234567));
    chk("R10 rx_valid after pop", {31'd0, cop_rx_valid}, 32'd0);

    for (int i = 0; i < 8; i++) hwrite(6'h20, msg(15 - i, 32'h0BEEF00 + i * 5));
    hread(6'h18, d); chk("R4 outbox full", d, stat(1, 1));
    chk("R7 no overflow yet", {31'd0, dbg_overflow}, 32'd0);
    hwrite(6'h20, 32'hDEAD_BEEF);
    chk("R7 overflow set", {31'd0, dbg_overflow}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      cpop(d); chk("R5 R7 outbox order", d, msg(15 - i, 32'h0BEEF00 + i * 5));
    end
    chk("R7 overflow sticky", {31'd0, dbg_overflow}, 32'd1);
    chk("R7 dropped word absent", {31'd0, cop_rx_valid}, 32'd0);

    cpush(msg(8, 32'h0777));
    for (int a = 0; a < 64; a++) begin
      if (a != 6'h00 && a != 6'h18 && a != 6'h20) begin
        hwrite(6'(a), 32'hFFFF_FFFF);
        hread(6'(a), d); chk("R9 unused offset", d, 32'd0);
      end
    end
    hwrite(6'h18, 32'h0);
    chk("R9 no outbox write", {31'd0, cop_rx_valid}, 32'd0);
    hread(6'h18, d); chk("R9 status unchanged", d, stat(0, 0));
    hread(6'h00, d); chk("R9 inbox intact", d, msg(8, 32'h0777));

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule